// File: doc/BRIEF.md
# Endpoint Identity Capture and Request Admission

This block sits on the transmit side of a PCIe-style endpoint function and owns its routing identity. The function's bus and device numbers are not known at reset. They are taken from each inbound type 0 configuration write the function receives. The captured numbers, together with a fixed local function number, form the 16-bit ID. That ID is stamped into every outgoing request as the requester ID. It is also presented on a plain output, for use as the completer ID in completions the function builds.

Local user requests pass through a valid/ready stream. Posted requests, such as memory writes, pass at any time. Non-posted requests, such as memory reads, are admitted only after an ID has been captured and while a tag is free. Each admitted non-posted request takes the lowest-numbered free tag. That tag stays busy until a completion returns carrying this function's current ID and that tag.

Back-pressure rules: the request stream is combinational from input to output, so `out_valid` and `req_ready` are driven in the same cycle as the request. A request that is not admitted shows `out_valid` low and `req_ready` low. An admitted request shows `out_valid` high, and `req_ready` then follows `out_ready`. A transfer happens only when `req_valid`, `req_ready` and `out_ready` are all high. A sender must hold its request stable while it waits.

Top module: `rid_gate_top`

## Requirements
- R1: Reset clears the ID-valid flag, the captured ID (`comp_id` reads 0) and every busy tag, so once a new ID is captured the tags are handed out again from 0 upward.
- R2: While the ID is invalid, a non-posted request (`req_np`=1) is not admitted: `out_valid`=0 and `req_ready`=0.
- R3: A posted request (`req_np`=0) is always admitted, whether or not an ID is valid and whether or not tags are free. It uses no tag and drives `out_tag`=0.
- R4: A configuration write with `cfg_wr_type0`=1 sets `id_valid` in the next cycle, and `comp_id` becomes {bus[15:8], device[7:3], FUNC_NUM[2:0]}.
- R5: Every later type 0 configuration write replaces both the bus and the device number in the same way.
- R6: A configuration write with `cfg_wr_type0`=0 changes neither `comp_id` nor `id_valid`.
- R7: Every outgoing request carries `out_req_id` equal to the current `comp_id`.
- R8: A non-posted transfer is given the lowest-numbered free tag on `out_tag`, and that tag becomes busy from the next cycle. A request that is offered but not transferred allocates nothing.
- R9: A completion frees its tag, starting in the next cycle, only when `cpl_req_id` equals the current `comp_id` and the tag is busy. Other completions are ignored.
- R10: While all NUM_TAGS tags are busy, non-posted requests are stalled (`req_ready`=0, `out_valid`=0) and posted requests still pass.
- R11: While a request is admitted, `req_ready` equals `out_ready`, so a stalled downstream holds the request back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_valid | input | 1 | Inbound configuration write strobe |
| cfg_wr_type0 | input | 1 | 1 = type 0 write addressed to this function |
| cfg_bus | input | 8 | Bus number carried by the configuration write |
| cfg_dev | input | 5 | Device number carried by the configuration write |
| req_valid | input | 1 | User request valid |
| req_ready | output | 1 | User request accepted |
| req_np | input | 1 | 1 = non-posted request, 0 = posted |
| req_addr | input | ADDR_W | Request address |
| out_valid | output | 1 | Outgoing request valid |
| out_ready | input | 1 | Downstream ready |
| out_np | output | 1 | Outgoing request is non-posted |
| out_addr | output | ADDR_W | Outgoing request address |
| out_req_id | output | 16 | Requester ID stamped into the header |
| out_tag | output | 8 | Tag of the outgoing non-posted request |
| cpl_valid | input | 1 | Inbound completion strobe |
| cpl_req_id | input | 16 | Requester ID carried by the completion |
| cpl_tag | input | 8 | Tag carried by the completion |
| id_valid | output | 1 | Captured ID is valid |
| comp_id | output | 16 | Captured ID, used as the completer ID |

## Verification
The bench builds the block with NUM_TAGS=4 and FUNC_NUM=2. The small tag pool can be filled in four transfers, so the full-pool stall, the reuse of a freed middle tag and the lowest-free order can all be reached in a short vector table. The non-zero function number makes the low three bits of every ID a value that can be checked. The table also re-captures the ID while tags are outstanding, which shows that completions still carrying the old ID leave their tags busy.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int ID_W  = BUS_W + DEV_W + FN_W;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
  } rid_t;
endpackage

// File: rtl/rid_capture.sv
module rid_capture
  import rid_pkg::*;
#(
  parameter logic [FN_W-1:0] FUNC_NUM = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_valid,
  input  logic             cfg_wr_type0,
  input  logic [BUS_W-1:0] cfg_bus,
  input  logic [DEV_W-1:0] cfg_dev,
  output logic             id_valid,
  output rid_t             id
);
  logic             have_id;
  logic [BUS_W-1:0] bus_q;
  logic [DEV_W-1:0] dev_q;
  logic             take;

  assign take = cfg_wr_valid && cfg_wr_type0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_id <= 1'b0;
      bus_q   <= '0;
      dev_q   <= '0;
    end else if (take) begin
      have_id <= 1'b1;
      bus_q   <= cfg_bus;
      dev_q   <= cfg_dev;
    end
  end

  assign id_valid = have_id;
  always_comb begin
    id.bus = bus_q;
    id.dev = dev_q;
    id.fn  = have_id ? FUNC_NUM : '0;
  end
endmodule

// File: rtl/rid_tag_pool.sv
module rid_tag_pool
  import rid_pkg::*;
#(
  parameter int NUM_TAGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             free_valid,
  input  logic [TAG_W-1:0] free_tag,
  output logic             avail,
  output logic [TAG_W-1:0] alloc_tag
);
  localparam int IDX_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1;

  logic [NUM_TAGS-1:0] busy_q;
  logic [NUM_TAGS-1:0] set_vec;
  logic [NUM_TAGS-1:0] clr_vec;
  logic [IDX_W-1:0]    first_free;
  logic                any_free;
  logic                free_in_range;

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        first_free = IDX_W'(i);
        any_free   = 1'b1;
      end
    end
  end

  assign free_in_range = (int'(free_tag) < NUM_TAGS);

  generate
    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
      assign set_vec[g] = alloc && any_free && (first_free == IDX_W'(g));
      assign clr_vec[g] = free_valid && free_in_range && busy_q[g]
                          && (free_tag == TAG_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~clr_vec) | set_vec;
  end

  assign avail     = any_free;
  assign alloc_tag = TAG_W'(first_free);
endmodule

// File: rtl/rid_admit.sv
module rid_admit (
  input  logic req_valid,
  input  logic req_np,
  input  logic out_ready,
  input  logic id_valid,
  input  logic tag_avail,
  output logic out_valid,
  output logic req_ready,
  output logic np_fire
);
  logic admit;

  assign admit     = !req_np || (id_valid && tag_avail);
  assign out_valid = req_valid && admit;
  assign req_ready = out_ready && admit;
  assign np_fire   = req_valid && req_np && admit && out_ready;
endmodule

// File: rtl/rid_gate_top.sv
module rid_gate_top
  import rid_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              NUM_TAGS = 32,
  parameter logic [2:0]      FUNC_NUM = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_valid,
  input  logic              cfg_wr_type0,
  input  logic [7:0]        cfg_bus,
  input  logic [4:0]        cfg_dev,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_np,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_np,
  output logic [ADDR_W-1:0] out_addr,
  output logic [15:0]       out_req_id,
  output logic [7:0]        out_tag,
  input  logic              cpl_valid,
  input  logic [15:0]       cpl_req_id,
  input  logic [7:0]        cpl_tag,
  output logic              id_valid,
  output logic [15:0]       comp_id
);
  rid_t             cur_id;
  logic             have_id;
  logic             tag_avail;
  logic             np_fire;
  logic             cpl_mine;
  logic [TAG_W-1:0] next_tag;

  rid_capture #(.FUNC_NUM(FUNC_NUM)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_type0 (cfg_wr_type0),
    .cfg_bus      (cfg_bus),
    .cfg_dev      (cfg_dev),
    .id_valid     (have_id),
    .id           (cur_id)
  );

  assign cpl_mine = cpl_valid && have_id && (cpl_req_id == cur_id);

  rid_tag_pool #(.NUM_TAGS(NUM_TAGS)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (np_fire),
    .free_valid (cpl_mine),
    .free_tag   (cpl_tag),
    .avail      (tag_avail),
    .alloc_tag  (next_tag)
  );

  rid_admit u_admit (
    .req_valid (req_valid),
    .req_np    (req_np),
    .out_ready (out_ready),
    .id_valid  (have_id),
    .tag_avail (tag_avail),
    .out_valid (out_valid),
    .req_ready (req_ready),
    .np_fire   (np_fire)
  );

  assign out_np     = req_np;
  assign out_addr   = req_addr;
  assign out_req_id = cur_id;
  assign out_tag    = req_np ? next_tag : '0;
  assign id_valid   = have_id;
  assign comp_id    = cur_id;
endmodule

// File: rtl/rid_gate_chk.sv
module rid_gate_chk #(
  parameter int NUM_TAGS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_valid,
  input logic        cfg_wr_type0,
  input logic [7:0]  cfg_bus,
  input logic [4:0]  cfg_dev,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_np,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_tag,
  input logic        id_valid,
  input logic [15:0] comp_id
);
  // R2
  np_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && req_valid && req_np) |-> (!out_valid && !req_ready));

  // R3
  posted_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_np) |-> (out_valid && req_ready == out_ready && out_tag == 8'd0));

  // R4
  id_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && cfg_wr_type0) |=> (id_valid && comp_id[15:3] == $past({cfg_bus, cfg_dev})));

  // R6
  type1_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && !cfg_wr_type0) |=> (comp_id == $past(comp_id) && id_valid == $past(id_valid)));

  // R8
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && req_np) |-> (int'(out_tag) < NUM_TAGS));

  // R11
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);
endmodule

bind rid_gate_top rid_gate_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_valid (cfg_wr_valid),
  .cfg_wr_type0 (cfg_wr_type0),
  .cfg_bus      (cfg_bus),
  .cfg_dev      (cfg_dev),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_np       (req_np),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_tag      (out_tag),
  .id_valid     (id_valid),
  .comp_id      (comp_id)
);

// File: tb/rid_gate_top_tb.sv
module rid_gate_top_tb;
  localparam int ADDR_W = 16;
  localparam int NT     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_valid = 1'b0, cfg_wr_type0 = 1'b0;
  logic [7:0]        cfg_bus = '0;
  logic [4:0]        cfg_dev = '0;
  logic              req_valid = 1'b0, req_np = 1'b0, out_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, out_valid, out_np, id_valid;
  logic [ADDR_W-1:0] out_addr;
  logic [15:0]       out_req_id, comp_id;
  logic [7:0]        out_tag;
  logic              cpl_valid = 1'b0;
  logic [15:0]       cpl_req_id = '0;
  logic [7:0]        cpl_tag = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rid_gate_top #(.ADDR_W(ADDR_W), .NUM_TAGS(NT), .FUNC_NUM(3'd2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_type0(cfg_wr_type0),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .req_valid(req_valid), .req_ready(req_ready),
    .req_np(req_np), .req_addr(req_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_np(out_np), .out_addr(out_addr), .out_req_id(out_req_id), .out_tag(out_tag),
    .cpl_valid(cpl_valid), .cpl_req_id(cpl_req_id), .cpl_tag(cpl_tag),
    .id_valid(id_valid), .comp_id(comp_id)
  );

  typedef struct packed {
    logic [23:0] rq;
    logic        cv, ct0;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic        rv, np, ordy, pv;
    logic [15:0] pid;
    logic [7:0]  ptag;
    logic        e_rrdy, e_ov;
    logic [7:0]  e_tag;
    logic        e_idv;
    logic [15:0] e_id;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{"R2 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b0,1'b0,8'd0, 1'b0,16'h0000},
    '{"R3 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b0,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd0, 1'b0,16'h0000},
    '{"R6 ", 1'b1,1'b0,8'h11,5'h03, 1'b0,1'b0,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b0,8'd0, 1'b0,16'h0000},
    '{"R6 ", 1'b1,1'b1,8'h03,5'h00, 1'b0,1'b0,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b0,8'd0, 1'b0,16'h0000},
    '{"R4 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd0, 1'b1,16'h0302},
    '{"R8 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd1, 1'b1,16'h0302},
    '{"R11", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b0, 1'b0,16'h0000,8'd0, 1'b0,1'b1,8'd2, 1'b1,16'h0302},
    '{"R8 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd2, 1'b1,16'h0302},
    '{"R8 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd3, 1'b1,16'h0302},
    '{"R10", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b0,1'b0,8'd0, 1'b1,16'h0302},
    '{"R10", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b0,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd0, 1'b1,16'h0302},
    '{"R9 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b1,16'h0302,8'd1, 1'b0,1'b0,8'd0, 1'b1,16'h0302},
    '{"R9 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b1,16'h0402,8'd2, 1'b1,1'b1,8'd1, 1'b1,16'h0302},
    '{"R9 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b0,1'b0,8'd0, 1'b1,16'h0302},
    '{"R5 ", 1'b1,1'b1,8'h7A,5'h1F, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b0,1'b0,8'd0, 1'b1,16'h0302},
    '{"R5 ", 1'b0,1'b0,8'h00,5'h00, 1'b0,1'b0,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b0,8'd0, 1'b1,16'h7AFA},
    '{"R9 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b1,16'h0302,8'd0, 1'b0,1'b0,8'd0, 1'b1,16'h7AFA},
    '{"R9 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b1,16'h7AFA,8'd3, 1'b0,1'b0,8'd0, 1'b1,16'h7AFA},
    '{"R7 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd3, 1'b1,16'h7AFA},
    '{"R9 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b1,16'h7AFA,8'd0, 1'b0,1'b0,8'd0, 1'b1,16'h7AFA},
    '{"R8 ", 1'b0,1'b0,8'h00,5'h00, 1'b1,1'b1,1'b1, 1'b0,16'h0000,8'd0, 1'b1,1'b1,8'd0, 1'b1,16'h7AFA}
  };

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr_valid = 1'b0; cfg_wr_type0 = 1'b0; req_valid = 1'b0; req_np = 1'b0;
    out_ready = 1'b1; cpl_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "id_valid after reset", int'(id_valid), 0);
    chk("R1", "comp_id after reset", int'(comp_id), 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_wr_valid = VEC[v].cv;  cfg_wr_type0 = VEC[v].ct0;
      cfg_bus = VEC[v].bus;      cfg_dev = VEC[v].dev;
      req_valid = VEC[v].rv;     req_np = VEC[v].np;  out_ready = VEC[v].ordy;
      req_addr = ADDR_W'(16'h1000 + v);
      cpl_valid = VEC[v].pv;     cpl_req_id = VEC[v].pid; cpl_tag = VEC[v].ptag;
      #1;
      chk(string'(VEC[v].rq), $sformatf("v%0d req_ready", v), int'(req_ready), int'(VEC[v].e_rrdy));
      chk(string'(VEC[v].rq), $sformatf("v%0d out_valid", v), int'(out_valid), int'(VEC[v].e_ov));
      chk(string'(VEC[v].rq), $sformatf("v%0d id_valid", v), int'(id_valid), int'(VEC[v].e_idv));
      chk(string'(VEC[v].rq), $sformatf("v%0d comp_id", v), int'(comp_id), int'(VEC[v].e_id));
      if (VEC[v].e_ov) begin
        // R7: header ID follows captured ID
        chk("R7", $sformatf("v%0d out_req_id", v), int'(out_req_id), int'(VEC[v].e_id));
        chk("R7", $sformatf("v%0d out_addr", v), int'(out_addr), 16'h1000 + v);
        chk(string'(VEC[v].rq), $sformatf("v%0d out_tag", v), int'(out_tag),
            VEC[v].np ? int'(VEC[v].e_tag) : 0);
      end
    end

    // R1: reset in the middle of a busy pool
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_np = 1'b1;
    #1;
    chk("R1", "id_valid after mid reset", int'(id_valid), 0);
    chk("R1", "comp_id after mid reset", int'(comp_id), 0);
    chk("R2", "np ready after mid reset", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_wr_valid = 1'b1; cfg_wr_type0 = 1'b1; cfg_bus = 8'h05; cfg_dev = 5'h02;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    #1;
    chk("R4", "comp_id recaptured", int'(comp_id), 16'h0512);
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      req_valid = 1'b1; req_np = 1'b1;
      #1;
      chk("R1", $sformatf("tag %0d after reset ready", t), int'(req_ready), 1);
      chk("R1", $sformatf("tag order %0d", t), int'(out_tag), t);
    end
    @(negedge clk);
    #1;
    chk("R10", "stall after refill", int'(req_ready), 0);
    @(negedge clk);
    idle_inputs();
    finish_run();
  end
endmodule